// File: doc/BRIEF.md
# Two-Wire Register Bank Slave

This block is a two-wire (I2C-compatible) slave that lets a host controller read and write a bank of byte-wide control registers. The bus lines are sampled by the block's own clock. The block finds start and stop conditions itself, matches the device address, acknowledges bytes and shifts read data out. The first byte of every transfer carries a 7-bit device address and a direction bit. On a write, the next byte selects a register index, and every data byte after it goes to the selected register, after which the index steps up by one. A read works the same way. The host first writes the index. It then issues a repeated start and sends the address with the direction bit set. The slave returns bytes from that index onward, moving forward each time the host acknowledges.

The device address has six fixed upper bits, `010101`, then one bit taken from a strap input. This lets two of these slaves share one bus. The register contents also appear in parallel on `regs_o`, so that the surrounding logic can use them directly. The data line is never driven high: the block outputs only a pull-low enable.

The controller moves through these states:
- `ST_IDLE`: waits for a start.
- `ST_DEV_ADDR`: takes in the address byte.
- `ST_ACK_DEV`: acknowledges the address byte.
- `ST_SUB_ADDR`: takes in the register index.
- `ST_ACK_SUB`: acknowledges the index.
- `ST_WR_DATA`: takes in a write byte.
- `ST_ACK_WR`: acknowledges the write byte.
- `ST_RD_DATA`: shifts out a read byte.
- `ST_MST_ACK`: samples the host's acknowledge.

The transitions are:
- Start, from any state, goes to `ST_DEV_ADDR`.
- Stop, from any state, goes to `ST_IDLE`.
- `ST_DEV_ADDR`, once the byte is complete: to `ST_ACK_DEV` if the address matches, otherwise to `ST_IDLE`.
- `ST_ACK_DEV`: to `ST_SUB_ADDR` on a write, or to `ST_RD_DATA` on a read.
- `ST_SUB_ADDR`: to `ST_ACK_SUB` if the index is valid, otherwise to `ST_IDLE`.
- `ST_ACK_SUB` and `ST_ACK_WR`: both go to `ST_WR_DATA`.
- `ST_WR_DATA`: to `ST_ACK_WR` if the index is in range, otherwise to `ST_IDLE`.
- `ST_RD_DATA`: to `ST_MST_ACK`.
- `ST_MST_ACK`: back to `ST_RD_DATA` on an acknowledge, or to `ST_IDLE` on a no-acknowledge.

Top module: `regbank_i2c_slave`

## Requirements
- R1: The address byte is `{6'b010101, strap, rw}`, sent MSB first. When it matches, the slave acknowledges by holding SDA low during the ninth clock. When it does not match (for example 8'h20), the slave never drives SDA until the next start.
- R2: In a write (rw = 0), the second byte is a register index from 0 to NUM_REGS-1 and is acknowledged. Each data byte after it is acknowledged and stored at the current index, and the index then increments.
- R3: An index byte of NUM_REGS or above (for example 8'h13 or 8'hFF with 19 registers) is not acknowledged. The slave goes idle, and no register changes.
- R4: A write byte that arrives after register NUM_REGS-1 has been written in the same burst is not acknowledged and is discarded. The slave goes idle, and the top register keeps its value.
- R5: A read is an index write, then a repeated start, then the address with rw = 1. The slave returns the register at the index, MSB first, and moves to the next register on each host acknowledge.
- R6: A read burst that runs past register NUM_REGS-1 keeps returning the top register's value until the host sends a no-acknowledge (SDA high on the ninth clock). After that the slave releases SDA.
- R7: A stop condition at any point returns the slave to idle. A partially received byte is discarded.
- R8: A start condition at any point abandons the transfer in progress, discards any partial byte, and begins a new address phase.
- R9: SDA is open drain. `sda_pull_o` = 1 pulls the line low, and the output changes only while SCL is low.
- R10: After reset every register reads 8'h00 and SDA is released.
- R11: With strap = 1 the write address byte is 8'h56 and the read address byte is 8'h57, and 8'h54 is refused. With strap = 0 the address bytes are 8'h54 and 8'h55, and 8'h56 is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| addr_strap_i | input | 1 | Strapped low bit of the device address |
| sda_pull_o | output | 1 | 1 = pull SDA low (open-drain enable) |
| regs_o | output | NUM_REGS*8 | Register contents; register k in bits [8k+7:8k] |

## Verification
The bench covers several failure points:
- **Boundary of the register range.** It writes an index just past the top and 8'hFF, and a burst that crosses the last register. A design that compares with the wrong bound would acknowledge or store a byte that must be dropped.
- **Burst reads across the top.** If the read side wraps to register 0 instead of repeating the top register, the mismatch shows up in the returned byte.
- **Bus conditions that arrive mid-byte.** A stop or start partway through a write byte must leave the target register unchanged, and a fresh transfer must then be acknowledged normally. A design that commits partial shifts, or fails to restart its bit count, fails here.
- **Strap bit and timing of the pull-low enable.** The bench flips the strap bit and watches the pull-low enable change while SCL is high. This catches an inverted address bit or an acknowledge driven on the wrong edge.

// File: rtl/regbank_i2c_pkg.sv
package regbank_i2c_pkg;

    localparam int BYTE_W = 8;

    // Fixed upper six bits of the 7-bit device address
    localparam logic [5:0] DEV_ID_HI = 6'b010101;

    typedef enum logic [3:0] {
        ST_IDLE     = 4'd0,
        ST_DEV_ADDR = 4'd1,
        ST_ACK_DEV  = 4'd2,
        ST_SUB_ADDR = 4'd3,
        ST_ACK_SUB  = 4'd4,
        ST_WR_DATA  = 4'd5,
        ST_ACK_WR   = 4'd6,
        ST_RD_DATA  = 4'd7,
        ST_MST_ACK  = 4'd8
    } slv_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2   // must be 2 or more
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] scl_pipe;
    logic [TOP:0] sda_pipe;
    logic         scl_d;
    logic         sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[TOP-1:0], scl_i};
            sda_pipe <= {sda_pipe[TOP-1:0], sda_i};
            scl_d    <= scl_pipe[TOP];
            sda_d    <= sda_pipe[TOP];
        end
    end

    assign scl_o      = scl_pipe[TOP];
    assign sda_o      = sda_pipe[TOP];
    assign scl_rise_o = scl_o & ~scl_d;
    assign scl_fall_o = ~scl_o & scl_d;
    // SDA edges while SCL stays high mark bus conditions
    assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
    assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;

endmodule

// File: rtl/regbank_store.sv
module regbank_store #(
    parameter int NUM_REGS = 19,
    parameter int DATA_W   = 8,
    parameter int IDX_W    = $clog2(NUM_REGS + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en_i,
    input  logic [IDX_W-1:0]           wr_idx_i,
    input  logic [DATA_W-1:0]          wr_data_i,
    input  logic [IDX_W-1:0]           rd_idx_i,
    output logic [DATA_W-1:0]          rd_data_o,
    output logic [NUM_REGS*DATA_W-1:0] regs_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

    logic [IDX_W-1:0] rd_sel;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_cell
        logic [DATA_W-1:0] cell_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cell_q <= '0;
            end else if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
                cell_q <= wr_data_i;
            end
        end
        assign regs_o[g*DATA_W +: DATA_W] = cell_q;
    end

    // Indices past the top read the top register
    assign rd_sel    = (rd_idx_i > LAST_IDX) ? LAST_IDX : rd_idx_i;
    assign rd_data_o = regs_o[rd_sel*DATA_W +: DATA_W];

endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
    import regbank_i2c_pkg::*;
#(
    parameter int NUM_REGS = 19,
    parameter int IDX_W    = $clog2(NUM_REGS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              strap_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              wr_en_o,
    output logic [IDX_W-1:0]  wr_idx_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic [IDX_W-1:0]  ptr_o,
    output logic              sda_pull_o,
    output slv_state_e        state_o
);

    localparam logic [BYTE_W-1:0] REG_COUNT_B = BYTE_W'(NUM_REGS);
    localparam logic [IDX_W-1:0]  REG_COUNT_I = IDX_W'(NUM_REGS);
    localparam logic [IDX_W-1:0]  LAST_IDX    = IDX_W'(NUM_REGS - 1);

    slv_state_e        state, state_n;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] tx_q;
    logic [2:0]        bit_cnt;
    logic [IDX_W-1:0]  ptr;
    logic              rw_q;
    logic              ack_phase;
    logic              sda_pull;

    logic [BYTE_W-1:0] rx_byte;
    logic              last_bit;
    logic              addr_hit;
    logic              sub_ok;
    logic              ptr_ok;

    assign rx_byte  = {shreg[BYTE_W-2:0], sda_s_i};
    assign last_bit = (bit_cnt == 3'd7);
    assign addr_hit = (rx_byte[7:1] == {DEV_ID_HI, strap_i});
    assign sub_ok   = (rx_byte < REG_COUNT_B);
    assign ptr_ok   = (ptr < REG_COUNT_I);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Next-state logic
    always_comb begin
        state_n = state;
        if (stop_i) begin
            state_n = ST_IDLE;
        end else if (start_i) begin
            state_n = ST_DEV_ADDR;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    state_n = ST_IDLE;
                end
                ST_DEV_ADDR: begin
                    if (scl_rise_i && last_bit)
                        state_n = addr_hit ? ST_ACK_DEV : ST_IDLE;
                end
                ST_SUB_ADDR: begin
                    if (scl_rise_i && last_bit)
                        state_n = sub_ok ? ST_ACK_SUB : ST_IDLE;
                end
                ST_WR_DATA: begin
                    if (scl_rise_i && last_bit)
                        state_n = ptr_ok ? ST_ACK_WR : ST_IDLE;
                end
                ST_ACK_DEV: begin
                    if (scl_fall_i && ack_phase)
                        state_n = rw_q ? ST_RD_DATA : ST_SUB_ADDR;
                end
                ST_ACK_SUB, ST_ACK_WR: begin
                    if (scl_fall_i && ack_phase)
                        state_n = ST_WR_DATA;
                end
                ST_RD_DATA: begin
                    if (scl_rise_i && last_bit)
                        state_n = ST_MST_ACK;
                end
                ST_MST_ACK: begin
                    if (scl_rise_i && !ack_phase && sda_s_i)
                        state_n = ST_IDLE;
                    else if (scl_fall_i && ack_phase)
                        state_n = ST_RD_DATA;
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            tx_q      <= '0;
            bit_cnt   <= '0;
            ptr       <= '0;
            rw_q      <= 1'b0;
            ack_phase <= 1'b0;
            sda_pull  <= 1'b0;
        end else if (stop_i || start_i || (state_n == ST_IDLE)) begin
            bit_cnt   <= '0;
            ack_phase <= 1'b0;
            sda_pull  <= 1'b0;
        end else begin
            unique case (state)
                ST_DEV_ADDR, ST_SUB_ADDR, ST_WR_DATA: begin
                    if (scl_rise_i) begin
                        shreg   <= rx_byte;
                        bit_cnt <= bit_cnt + 3'd1;
                        if (last_bit) begin
                            ack_phase <= 1'b0;
                            if (state == ST_DEV_ADDR) rw_q <= rx_byte[0];
                            if (state == ST_SUB_ADDR) ptr <= rx_byte[IDX_W-1:0];
                            if (state == ST_WR_DATA)  ptr <= ptr + 1'b1;
                        end
                    end
                end
                ST_ACK_DEV, ST_ACK_SUB, ST_ACK_WR: begin
                    if (scl_fall_i) begin
                        if (!ack_phase) begin
                            sda_pull  <= 1'b1;
                            ack_phase <= 1'b1;
                        end else begin
                            ack_phase <= 1'b0;
                            bit_cnt   <= '0;
                            if ((state == ST_ACK_DEV) && rw_q) begin
                                tx_q     <= rd_data_i;
                                sda_pull <= ~rd_data_i[BYTE_W-1];
                            end else begin
                                sda_pull <= 1'b0;
                            end
                        end
                    end
                end
                ST_RD_DATA: begin
                    if (scl_rise_i) begin
                        bit_cnt <= bit_cnt + 3'd1;
                        if (last_bit) ack_phase <= 1'b0;
                    end
                    if (scl_fall_i) begin
                        tx_q     <= {tx_q[BYTE_W-2:0], 1'b0};
                        sda_pull <= ~tx_q[BYTE_W-2];
                    end
                end
                ST_MST_ACK: begin
                    if (scl_fall_i && !ack_phase) begin
                        sda_pull <= 1'b0;
                    end
                    if (scl_rise_i && !ack_phase && !sda_s_i) begin
                        ack_phase <= 1'b1;
                        if (ptr < LAST_IDX) ptr <= ptr + 1'b1;
                    end
                    if (scl_fall_i && ack_phase) begin
                        tx_q      <= rd_data_i;
                        sda_pull  <= ~rd_data_i[BYTE_W-1];
                        ack_phase <= 1'b0;
                        bit_cnt   <= '0;
                    end
                end
                ST_IDLE: begin
                    sda_pull <= 1'b0;
                end
                default: begin
                    sda_pull <= 1'b0;
                end
            endcase
        end
    end

    assign wr_en_o    = (state == ST_WR_DATA) && scl_rise_i && last_bit &&
                        ptr_ok && !start_i && !stop_i;
    assign wr_idx_o   = ptr;
    assign wr_data_o  = rx_byte;
    assign ptr_o      = ptr;
    assign sda_pull_o = sda_pull;
    assign state_o    = state;

endmodule

// File: rtl/regbank_i2c_slave.sv
module regbank_i2c_slave
    import regbank_i2c_pkg::*;
#(
    parameter int NUM_REGS    = 19,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_i,
    input  logic                       sda_i,
    input  logic                       addr_strap_i,
    output logic                       sda_pull_o,
    output logic [NUM_REGS*BYTE_W-1:0] regs_o
);

    localparam int IDX_W = $clog2(NUM_REGS + 1);

    logic              scl_sync;
    logic              sda_sync;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_seen;
    logic              stop_seen;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [BYTE_W-1:0] wr_data;
    logic [IDX_W-1:0]  ptr;
    logic [BYTE_W-1:0] rd_data;
    slv_state_e        fsm_state;

    i2c_line_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_o     (scl_sync),
        .sda_o     (sda_sync),
        .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall),
        .start_o   (start_seen),
        .stop_o    (stop_seen)
    );

    i2c_slave_fsm #(
        .NUM_REGS(NUM_REGS),
        .IDX_W   (IDX_W)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s_i   (sda_sync),
        .scl_rise_i(scl_rise),
        .scl_fall_i(scl_fall),
        .start_i   (start_seen),
        .stop_i    (stop_seen),
        .strap_i   (addr_strap_i),
        .rd_data_i (rd_data),
        .wr_en_o   (wr_en),
        .wr_idx_o  (wr_idx),
        .wr_data_o (wr_data),
        .ptr_o     (ptr),
        .sda_pull_o(sda_pull_o),
        .state_o   (fsm_state)
    );

    regbank_store #(
        .NUM_REGS(NUM_REGS),
        .DATA_W  (BYTE_W),
        .IDX_W   (IDX_W)
    ) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en),
        .wr_idx_i (wr_idx),
        .wr_data_i(wr_data),
        .rd_idx_i (ptr),
        .rd_data_o(rd_data),
        .regs_o   (regs_o)
    );

endmodule

// File: rtl/regbank_i2c_checker.sv
module regbank_i2c_checker
    import regbank_i2c_pkg::*;
#(
    parameter int NUM_REGS = 19,
    parameter int IDX_W    = $clog2(NUM_REGS + 1)
) (
    input logic                       clk,
    input logic                       rst_n,
    input slv_state_e                 state,
    input logic                       sda_pull,
    input logic                       scl_s,
    input logic                       start_seen,
    input logic                       stop_seen,
    input logic                       wr_en,
    input logic [IDX_W-1:0]           wr_idx,
    input logic [IDX_W-1:0]           ptr,
    input logic [NUM_REGS*BYTE_W-1:0] regs
);

    localparam logic [IDX_W-1:0] REG_COUNT_I = IDX_W'(NUM_REGS);

    // R9: the pull-low enable moves only while SCL is low
    p_pull_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull != $past(sda_pull)) |-> !scl_s);

    // R7: nothing is driven while idle
    p_idle_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_pull);

    // R7: a stop always lands in idle
    p_stop_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_seen |=> (state == ST_IDLE));

    // R8: a start always begins an address phase
    p_start_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_seen && !stop_seen) |=> (state == ST_DEV_ADDR));

    // R4: writes never target an index outside the bank
    p_write_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < REG_COUNT_I));

    // R6: the pointer never exceeds one past the top
    p_ptr_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= REG_COUNT_I);

    // R3: register contents change only on a write strobe
    p_regs_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs));

    // R2: an acknowledged index is always inside the bank
    p_sub_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACK_SUB) |-> (ptr < REG_COUNT_I));

endmodule

bind regbank_i2c_slave regbank_i2c_checker #(
    .NUM_REGS(NUM_REGS),
    .IDX_W   (IDX_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (fsm_state),
    .sda_pull  (sda_pull_o),
    .scl_s     (scl_sync),
    .start_seen(start_seen),
    .stop_seen (stop_seen),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .ptr       (ptr),
    .regs      (regs_o)
);

// File: tb/regbank_i2c_slave_tb.sv
module regbank_i2c_slave_tb_top;

    localparam int NREG = 19;
    localparam int Q    = 8;   // clk cycles per quarter SCL period

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_drv = 1'b1;
    logic sda_m = 1'b1;
    logic strap = 1'b0;
    logic sda_pull;
    logic sda_bus;
    logic [NREG*8-1:0] regs;

    int checks = 0;
    int failures = 0;
    int r9_viol = 0;
    bit done = 1'b0;
    logic [7:0] model [NREG];

    always #2.5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_pull;

    regbank_i2c_slave #(.NUM_REGS(NREG)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_drv),
        .sda_i       (sda_bus),
        .addr_strap_i(strap),
        .sda_pull_o  (sda_pull),
        .regs_o      (regs)
    );

    // R9 monitor: enable must not move while the driven SCL is high
    logic pull_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && (sda_pull != pull_prev) && scl_drv) r9_viol++;
        pull_prev <= sda_pull;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic waitq(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; waitq(1);
        scl_drv = 1'b1; waitq(1);
        sda_m = 1'b0; waitq(1);
        scl_drv = 1'b0; waitq(1);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; waitq(1);
        scl_drv = 1'b1; waitq(1);
        sda_m = 1'b1; waitq(1);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; waitq(1);
            scl_drv = 1'b1; waitq(2);
            scl_drv = 1'b0; waitq(1);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        sda_m = 1'b1; waitq(1);
        scl_drv = 1'b1; waitq(1);
        ack = !sda_bus; waitq(1);
        scl_drv = 1'b0; waitq(1);
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; waitq(1);
            scl_drv = 1'b1; waitq(1);
            b[i] = sda_bus; waitq(1);
            scl_drv = 1'b0; waitq(1);
        end
        sda_m = mack ? 1'b0 : 1'b1; waitq(1);
        scl_drv = 1'b1; waitq(2);
        scl_drv = 1'b0; waitq(1);
        sda_m = 1'b1;
    endtask

    task automatic write_one(input logic [7:0] wa, input logic [7:0] sub, input logic [7:0] d, output bit ok);
        bit a0, a1, a2;
        i2c_start();
        send_byte(wa, a0);
        send_byte(sub, a1);
        send_byte(d, a2);
        i2c_stop();
        ok = a0 && a1 && a2;
    endtask

    task automatic read_one(input logic [7:0] wa, input logic [7:0] sub, output logic [7:0] v, output bit ok);
        bit a0, a1, a2;
        i2c_start();
        send_byte(wa, a0);
        send_byte(sub, a1);
        i2c_start();
        send_byte(wa | 8'h01, a2);
        recv_byte(1'b0, v);
        i2c_stop();
        ok = a0 && a1 && a2;
    endtask

    task automatic check_model(input string tag);
        for (int k = 0; k < NREG; k++)
            check(regs[k*8 +: 8] == model[k], tag, {24'd0, regs[k*8 +: 8]}, {24'd0, model[k]});
    endtask

    // sub, data pairs for the write/read-back loop
    localparam logic [15:0] VEC [8] = '{
        16'h00A5, 16'h015A, 16'h07FF, 16'h0900,
        16'h0C3C, 16'h1281, 16'h03C3, 16'h0F7E
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        bit ok, a0, a1, a2, a3;
        logic [7:0] v, v1, v2, v3, v4;
        for (int k = 0; k < NREG; k++) model[k] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R10: reset state
        check(regs == '0, "R10 regs zero", {31'd0, |regs}, 32'd0);
        check(sda_pull == 1'b0, "R10 sda released", {31'd0, sda_pull}, 32'd0);

        // R2 / R5: table-driven single writes and read-backs
        for (int i = 0; i < 8; i++) begin
            write_one(8'h54, VEC[i][15:8], VEC[i][7:0], ok);
            model[VEC[i][15:8]] = VEC[i][7:0];
            check(ok, "R2 write acked", {31'd0, ok}, 32'd1);
            read_one(8'h54, VEC[i][15:8], v, ok);
            check(ok, "R5 read acked", {31'd0, ok}, 32'd1);
            check(v == VEC[i][7:0], "R5 read data", {24'd0, v}, {24'd0, VEC[i][7:0]});
        end
        check_model("R2 bank contents");

        // R2 / R4: burst write crossing the top register
        i2c_start();
        send_byte(8'h54, a0);
        send_byte(8'd16, a1);
        send_byte(8'h11, a2); check(a2, "R2 burst byte 16", {31'd0, a2}, 32'd1);
        send_byte(8'h22, a2); check(a2, "R2 burst byte 17", {31'd0, a2}, 32'd1);
        send_byte(8'h33, a2); check(a2, "R2 burst byte 18", {31'd0, a2}, 32'd1);
        send_byte(8'h44, a3); check(!a3, "R4 past-top nack", {31'd0, a3}, 32'd0);
        i2c_stop();
        model[16] = 8'h11; model[17] = 8'h22; model[18] = 8'h33;
        check_model("R4 top kept");

        // R3: invalid subaddresses
        i2c_start();
        send_byte(8'h54, a0);
        send_byte(8'h13, a1); check(!a1, "R3 sub 19 nack", {31'd0, a1}, 32'd0);
        send_byte(8'hEE, a2); check(!a2, "R3 idle after nack", {31'd0, a2}, 32'd0);
        i2c_stop();
        i2c_start();
        send_byte(8'h54, a0);
        send_byte(8'hFF, a1); check(!a1, "R3 sub FF nack", {31'd0, a1}, 32'd0);
        i2c_stop();
        check_model("R3 bank untouched");

        // R1 / R11: foreign addresses
        i2c_start();
        send_byte(8'h20, a0); check(!a0, "R1 foreign addr nack", {31'd0, a0}, 32'd0);
        i2c_stop();
        i2c_start();
        send_byte(8'h56, a0); check(!a0, "R11 strap0 rejects 56", {31'd0, a0}, 32'd0);
        i2c_stop();

        // R5 / R6: read burst from 17 across the top
        i2c_start();
        send_byte(8'h54, a0);
        send_byte(8'd17, a1);
        i2c_start();
        send_byte(8'h55, a2); check(a2, "R1 read addr ack", {31'd0, a2}, 32'd1);
        recv_byte(1'b1, v1);
        recv_byte(1'b1, v2);
        recv_byte(1'b1, v3);
        recv_byte(1'b0, v4);
        check(v1 == 8'h22, "R5 burst reg17", {24'd0, v1}, 32'h22);
        check(v2 == 8'h33, "R5 burst reg18", {24'd0, v2}, 32'h33);
        check(v3 == 8'h33, "R6 saturate 1", {24'd0, v3}, 32'h33);
        check(v4 == 8'h33, "R6 saturate 2", {24'd0, v4}, 32'h33);
        check(sda_pull == 1'b0, "R6 released after nack", {31'd0, sda_pull}, 32'd0);
        i2c_stop();

        // R7: stop in the middle of a data byte
        i2c_start();
        send_byte(8'h54, a0);
        send_byte(8'd5, a1);
        send_bits(8'hF0, 4);
        i2c_stop();
        check_model("R7 partial byte dropped");
        read_one(8'h54, 8'd5, v, ok);
        check(ok && v == 8'h00, "R7 reg5 after stop", {24'd0, v}, 32'h00);

        // R8: start in the middle of a data byte
        i2c_start();
        send_byte(8'h54, a0);
        send_byte(8'd6, a1);
        send_bits(8'h0F, 3);
        i2c_start();
        send_byte(8'h54, a0); check(a0, "R8 restart addr ack", {31'd0, a0}, 32'd1);
        send_byte(8'd6, a1);
        send_byte(8'h3C, a2); check(a1 && a2, "R8 restart write ack", {31'd0, a2}, 32'd1);
        i2c_stop();
        model[6] = 8'h3C;
        check_model("R8 bank after restart");

        // R11: strap selects the low address bit
        strap = 1'b1;
        i2c_start();
        send_byte(8'h54, a0); check(!a0, "R11 strap1 rejects 54", {31'd0, a0}, 32'd0);
        i2c_stop();
        write_one(8'h56, 8'd2, 8'h99, ok);
        check(ok, "R11 strap1 write ack", {31'd0, ok}, 32'd1);
        model[2] = 8'h99;
        read_one(8'h56, 8'd2, v, ok);
        check(ok && v == 8'h99, "R11 strap1 read", {24'd0, v}, 32'h99);
        strap = 1'b0;
        check_model("R11 bank");

        // R9: open-drain enable timing
        check(r9_viol == 0, "R9 pull moved with SCL high", r9_viol, 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule